// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Completion and Collision Flags

This block is an 8-bit SPI engine that a CPU reaches through a small register bus with two addresses, one for status and one for data. As master it makes its own serial clock from the system clock, puts one byte out on its serial output and takes one byte in on its serial input for each transfer. As slave it follows an external serial clock while its select input is low. The bus uses SPI mode 0 and sends the most significant bit first. The received byte goes to a buffer, so the CPU never sees the shift register while a byte is moving.

The status register holds a completion flag, a write-collision flag and a speed-doubling bit. The completion flag drives an interrupt request through an enable input. The flags clear when the CPU reads status while a flag is set and then accesses the data register. An interrupt acknowledge pulse also clears the completion flag. In master mode a low select input, when that input is configured as an input, sets the completion flag to signal a conflict with another master.

Top module: `spi_flagged_ctrl`

## Requirements
- R1: After reset, status and data read as 0x00, `irq_req` is low and `sck_o` is low.
- R2: With `reg_sel`=1 (data) a write in master mode starts a transfer. Status (`reg_sel`=0) bit 7 sets when the byte completes, and a data read then returns the byte received on `sdi`, MSB first.
- R3: `cfg_rate` 0/1/2/3 selects an SCK period of 4/16/64/128 system clocks, halved when status bit 0 is set. The completion flag sets exactly 16 half-periods after the clock edge that accepts the data write.
- R4: Status bit 0 is read/write. Bits 5 to 1 always read zero. Bits 7 and 6 cannot be changed by a status write.
- R5: A data write while a transfer is in progress sets status bit 6, is ignored, and leaves the byte in flight unchanged.
- R6: A status read that sees a flag set, followed by any data read or write, clears both flags.
- R7: A data access without a preceding flagged status read, or a status read alone, leaves the flags set.
- R8: `irq_req` is high exactly when the completion flag is set and `cfg_irq_en` is high. An `irq_ack` pulse clears the completion flag.
- R9: In master mode with `cfg_ss_input` high, a low `ss_n_i` sets the completion flag. With `cfg_ss_input` low it has no effect.
- R10: In slave mode with `ss_n_i` low, the block shifts in `sdi` on rising `sck_i`, drives the byte loaded by a data write on `sdo` (changing on falling `sck_i`), and sets the completion flag after the eighth rising edge.
- R11: A data read during a transfer returns the previously received byte, not partial shift contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 status, 1 data |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cfg_enable | input | 1 | Block enable |
| cfg_master | input | 1 | 1 master, 0 slave |
| cfg_rate | input | 2 | Master clock rate select |
| cfg_ss_input | input | 1 | In master mode, select pin acts as conflict input |
| cfg_irq_en | input | 1 | Interrupt enable |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| sck_o | output | 1 | Serial clock out (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_n_i | input | 1 | Active-low select input |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
In master mode the completion flag shows on `irq_req` exactly 16 half-periods after the edge that takes the data write. The bench samples one cycle before that point and at it, so an early or late flag is caught. Inputs that pass through the two-stage synchronizers (slave clock, select and data) need three edges to act. The bench waits four cycles after changing them and holds each slave clock phase for four cycles. Register reads are combinational and are sampled in the cycle the strobe is high. Clears take effect at that edge and are checked at the next falling edge.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int BYTE_W   = 8;
  localparam int ST_DONE  = 7;
  localparam int ST_COLL  = 6;
  localparam int ST_FAST  = 0;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_DATA = 1'b1} reg_sel_e;

  // half of the SCK period in system clocks
  function automatic int half_period(input logic [1:0] rate, input logic fast);
    int h;
    case (rate)
      2'd0:    h = 2;
      2'd1:    h = 8;
      2'd2:    h = 32;
      default: h = 64;
    endcase
    if (fast) h = h / 2;
    return h;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= RST_VAL;
        else        stg_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div
  import spi_flag_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  input  logic       fast,
  output logic       tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = CNT_W'(half_period(rate, fast) - 1);
    tick  = run && (cnt_q == limit);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master,
  input  logic              start,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic              sdi_m,
  input  logic              sdi_s,
  input  logic              sck_s,
  input  logic              ss_active,
  output logic              busy,
  output logic              sck_o,
  output logic              sdo,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CW  = $clog2(DATA_W + 1);
  localparam int MSB = DATA_W - 1;

  logic              m_busy_q, m_busy_d;
  logic              sck_q, sck_d;
  logic              sck_prev_q;
  logic              sdo_q, sdo_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              s_rise, s_fall;

  always_comb begin
    s_rise   = sck_s & ~sck_prev_q;
    s_fall   = ~sck_s & sck_prev_q;
    m_busy_d = m_busy_q;
    sck_d    = sck_q;
    sdo_d    = sdo_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    done     = 1'b0;
    rx_byte  = sh_q;
    if (!en) begin
      m_busy_d = 1'b0;
      sck_d    = 1'b0;
      cnt_d    = '0;
    end else if (master) begin
      if (start) begin
        m_busy_d = 1'b1;
        sh_d     = wdata;
        sdo_d    = wdata[MSB];
        cnt_d    = '0;
        sck_d    = 1'b0;
      end else if (m_busy_q && tick) begin
        sck_d = ~sck_q;
        if (!sck_q) begin
          sh_d  = {sh_q[MSB-1:0], sdi_m};
          cnt_d = cnt_q + 1'b1;
        end else if (cnt_q == CW'(DATA_W)) begin
          done     = 1'b1;
          m_busy_d = 1'b0;
          cnt_d    = '0;
        end else begin
          sdo_d = sh_q[MSB];
        end
      end
    end else begin
      m_busy_d = 1'b0;
      sck_d    = 1'b0;
      if (start) begin
        sh_d  = wdata;
        sdo_d = wdata[MSB];
      end
      if (!ss_active) begin
        cnt_d = '0;
      end else if (s_rise) begin
        sh_d = {sh_q[MSB-1:0], sdi_s};
        if (cnt_q == CW'(DATA_W - 1)) begin
          done    = 1'b1;
          cnt_d   = '0;
          rx_byte = {sh_q[MSB-1:0], sdi_s};
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (s_fall) begin
        sdo_d = sh_q[MSB];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy_q   <= 1'b0;
      sck_q      <= 1'b0;
      sck_prev_q <= 1'b0;
      sdo_q      <= 1'b0;
      sh_q       <= '0;
      cnt_q      <= '0;
    end else begin
      m_busy_q   <= m_busy_d;
      sck_q      <= sck_d;
      sck_prev_q <= sck_s;
      sdo_q      <= sdo_d;
      sh_q       <= sh_d;
      cnt_q      <= cnt_d;
    end
  end

  assign busy  = master ? m_busy_q : (ss_active && cnt_q != '0);
  assign sck_o = sck_q;
  assign sdo   = (master || ss_active) ? sdo_q : 1'b0;
endmodule

// File: rtl/spi_status_regs.sv
module spi_status_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_rd,
  input  logic              st_wr,
  input  logic              fast_wbit,
  input  logic              dt_acc,
  input  logic              set_done,
  input  logic              set_coll,
  input  logic              irq_ack,
  input  logic              irq_en,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_byte,
  output logic              done_flag,
  output logic              coll_flag,
  output logic              fast,
  output logic [DATA_W-1:0] rx_buf,
  output logic              irq_req
);
  logic              done_q, done_d, coll_q, coll_d, fast_q, fast_d;
  logic              arm_done_q, arm_done_d, arm_coll_q, arm_coll_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    arm_done_d = arm_done_q;
    arm_coll_d = arm_coll_q;
    if (st_rd) begin
      arm_done_d = done_q;
      arm_coll_d = coll_q;
    end else if (dt_acc) begin
      arm_done_d = 1'b0;
      arm_coll_d = 1'b0;
    end

    done_d = done_q;
    coll_d = coll_q;
    if (dt_acc && arm_done_q) done_d = 1'b0;
    if (dt_acc && arm_coll_q) coll_d = 1'b0;
    if (irq_ack)              done_d = 1'b0;
    if (set_done)             done_d = 1'b1;
    if (set_coll)             coll_d = 1'b1;

    fast_d = st_wr ? fast_wbit : fast_q;
    rx_d   = cap_en ? cap_byte : rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      coll_q     <= 1'b0;
      fast_q     <= 1'b0;
      arm_done_q <= 1'b0;
      arm_coll_q <= 1'b0;
      rx_q       <= '0;
    end else begin
      done_q     <= done_d;
      coll_q     <= coll_d;
      fast_q     <= fast_d;
      arm_done_q <= arm_done_d;
      arm_coll_q <= arm_coll_d;
      rx_q       <= rx_d;
    end
  end

  assign done_flag = done_q;
  assign coll_flag = coll_q;
  assign fast      = fast_q;
  assign rx_buf    = rx_q;
  assign irq_req   = done_q & irq_en;
endmodule

// File: rtl/spi_flagged_ctrl.sv
module spi_flagged_ctrl
  import spi_flag_pkg::*;
#(
  parameter int DATA_W      = BYTE_W,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cfg_enable,
  input  logic              cfg_master,
  input  logic [1:0]        cfg_rate,
  input  logic              cfg_ss_input,
  input  logic              cfg_irq_en,
  output logic              irq_req,
  input  logic              irq_ack,
  output logic              sck_o,
  input  logic              sck_i,
  input  logic              ss_n_i,
  output logic              sdo,
  input  logic              sdi
);
  localparam logic [2:0] SYNC_RST = 3'b010;

  logic [1:0]        rst_q;
  logic              rst_n_i;
  logic [2:0]        pins_s;
  logic              sck_s, ss_n_s, sdi_s;
  logic              st_rd, st_wr, dt_wr, dt_acc;
  logic              busy, start, xfer_done, mode_fault, ss_active, tick;
  logic              done_flag, coll_flag, fast;
  logic [DATA_W-1:0] rx_byte, rx_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_i = rst_q[1];

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .d({sck_i, ss_n_i, sdi}), .q(pins_s)
  );
  assign {sck_s, ss_n_s, sdi_s} = pins_s;

  assign st_rd      = reg_rd & (reg_sel == SEL_STATUS);
  assign st_wr      = reg_wr & (reg_sel == SEL_STATUS);
  assign dt_wr      = reg_wr & (reg_sel == SEL_DATA);
  assign dt_acc     = (reg_rd | reg_wr) & (reg_sel == SEL_DATA);
  assign start      = dt_wr & cfg_enable & ~busy;
  assign ss_active  = cfg_enable & ~cfg_master & ~ss_n_s;
  assign mode_fault = cfg_enable & cfg_master & cfg_ss_input & ~ss_n_s;

  spi_rate_div #(.CNT_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n_i), .run(busy & cfg_master),
    .rate(cfg_rate), .fast(fast), .tick(tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n_i), .en(cfg_enable), .master(cfg_master),
    .start(start), .wdata(reg_wdata), .tick(tick), .sdi_m(sdi),
    .sdi_s(sdi_s), .sck_s(sck_s), .ss_active(ss_active), .busy(busy),
    .sck_o(sck_o), .sdo(sdo), .done(xfer_done), .rx_byte(rx_byte)
  );

  spi_status_regs #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n_i), .st_rd(st_rd), .st_wr(st_wr),
    .fast_wbit(reg_wdata[ST_FAST]), .dt_acc(dt_acc),
    .set_done(xfer_done | mode_fault), .set_coll(dt_wr & busy),
    .irq_ack(irq_ack), .irq_en(cfg_irq_en), .cap_en(xfer_done),
    .cap_byte(rx_byte), .done_flag(done_flag), .coll_flag(coll_flag),
    .fast(fast), .rx_buf(rx_buf), .irq_req(irq_req)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_STATUS) begin
      reg_rdata[ST_DONE] = done_flag;
      reg_rdata[ST_COLL] = coll_flag;
      reg_rdata[ST_FAST] = fast;
    end else begin
      reg_rdata = rx_buf;
    end
  end
endmodule

// File: rtl/spi_flag_checker.sv
module spi_flag_checker (
  input logic clk,
  input logic rst_n,
  input logic master,
  input logic busy,
  input logic sck_o,
  input logic xfer_done,
  input logic dt_wr,
  input logic done_flag,
  input logic coll_flag,
  input logic mode_fault,
  input logic irq_ack,
  input logic irq_en,
  input logic irq_req
);
  p_done_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> done_flag);

  p_sck_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy) |-> !sck_o);

  p_collision_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_wr && busy) |=> coll_flag);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !xfer_done && !mode_fault) |=> !done_flag);

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> irq_en);

  p_fault_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> done_flag);
endmodule

bind spi_flagged_ctrl spi_flag_checker u_chk (
  .clk(clk), .rst_n(rst_n_i), .master(cfg_master), .busy(busy),
  .sck_o(sck_o), .xfer_done(xfer_done), .dt_wr(dt_wr),
  .done_flag(done_flag), .coll_flag(coll_flag), .mode_fault(mode_fault),
  .irq_ack(irq_ack), .irq_en(cfg_irq_en), .irq_req(irq_req)
);

// File: tb/sim_spi_flagged_ctrl.sv
`timescale 1ns/1ps
module sim_spi_flagged_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_sel, reg_rd, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       cfg_enable, cfg_master, cfg_ss_input, cfg_irq_en;
  logic [1:0] cfg_rate;
  logic       irq_req, irq_ack, sck_o, sck_i, ss_n_i, sdo, sdi, sdi_drv, loop_en;
  int         checks = 0;
  int         fails  = 0;

  always #10 clk = ~clk;
  assign sdi = loop_en ? sdo : sdi_drv;

  spi_flagged_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_enable(cfg_enable), .cfg_master(cfg_master), .cfg_rate(cfg_rate),
    .cfg_ss_input(cfg_ss_input), .cfg_irq_en(cfg_irq_en), .irq_req(irq_req),
    .irq_ack(irq_ack), .sck_o(sck_o), .sck_i(sck_i), .ss_n_i(ss_n_i),
    .sdo(sdo), .sdi(sdi)
  );

  // {rate[1:0], fast, tx byte}
  localparam logic [10:0] VEC [4] = '{
    {2'd0, 1'b1, 8'hA5}, {2'd0, 1'b0, 8'h3C},
    {2'd1, 1'b0, 8'h81}, {2'd2, 1'b1, 8'h5A}
  };

  function automatic int half_of(input logic [1:0] r, input logic f);
    int h;
    h = (r == 2'd0) ? 2 : (r == 2'd1) ? 8 : (r == 2'd2) ? 32 : 64;
    return f ? h / 2 : h;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 5000; k++) begin
      if (irq_req) break;
      @(negedge clk);
    end
  endtask

  task automatic ack_pulse();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] d, got;
    int h;
    rst_n = 1'b0; reg_sel = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    cfg_enable = 1'b1; cfg_master = 1'b1; cfg_rate = 2'd0; cfg_ss_input = 1'b0;
    cfg_irq_en = 1'b1; irq_ack = 1'b0; sck_i = 1'b0; ss_n_i = 1'b1;
    sdi_drv = 1'b0; loop_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq_req, 0);
    chk("R1 sck", sck_o, 0);
    bus_rd(0, d); chk("R1 status", d, 8'h00);
    bus_rd(1, d); chk("R1 data", d, 8'h00);

    // R4 status write: only bit 0 sticks
    bus_wr(0, 8'hFF); bus_rd(0, d); chk("R4 writable bits", d, 8'h01);
    bus_wr(0, 8'h00); bus_rd(0, d); chk("R4 clear fast", d, 8'h00);

    // R2 R3 R6 master transfers with loopback
    for (int i = 0; i < 4; i++) begin
      cfg_rate = VEC[i][10:9];
      bus_wr(0, {7'b0, VEC[i][8]});
      bus_wr(1, VEC[i][7:0]);
      h = half_of(VEC[i][10:9], VEC[i][8]);
      repeat (16 * h - 1) @(negedge clk);
      chk("R3 not early", irq_req, 0);
      @(negedge clk);
      chk("R3 on time", irq_req, 1);
      bus_rd(0, d); chk("R2 R4 status", d, {7'h40, VEC[i][8]});
      bus_rd(1, d); chk("R2 rx byte", d, VEC[i][7:0]);
      chk("R6 flag cleared", irq_req, 0);
    end

    // R11 R5 R7 R6 slow transfer with collision
    cfg_rate = 2'd3;
    bus_wr(0, 8'h00);
    bus_wr(1, 8'hC3);
    repeat (100) @(negedge clk);
    bus_rd(1, d); chk("R11 buffer not live", d, 8'h5A);
    bus_wr(1, 8'h00);
    chk("R5 no irq on collision", irq_req, 0);
    wait_irq();
    chk("R5 completes", irq_req, 1);
    bus_rd(1, d); chk("R5 byte undisturbed", d, 8'hC3);
    chk("R7 unarmed data read keeps flag", irq_req, 1);
    bus_rd(0, d); chk("R5 both flags", d, 8'hC0);
    bus_rd(0, d); chk("R7 status read alone keeps flags", d, 8'hC0);
    bus_wr(1, 8'h00);
    wait_irq();
    bus_rd(0, d); bus_rd(1, d);
    bus_rd(0, d); chk("R6 write access clears", d, 8'h00);

    // R8 interrupt gating and acknowledge
    cfg_rate = 2'd0;
    bus_wr(0, 8'h01);
    bus_wr(1, 8'h66);
    wait_irq();
    @(negedge clk); cfg_irq_en = 1'b0;
    #1 chk("R8 gated off", irq_req, 0);
    @(negedge clk); cfg_irq_en = 1'b1;
    #1 chk("R8 gated on", irq_req, 1);
    ack_pulse();
    chk("R8 ack clears", irq_req, 0);
    bus_rd(0, d); chk("R8 status after ack", d, 8'h01);

    // R9 select conflict in master mode
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 ignored when not input", irq_req, 0);
    cfg_ss_input = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 conflict sets flag", irq_req, 1);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    ack_pulse();
    chk("R9 cleared after release", irq_req, 0);
    cfg_ss_input = 1'b0;

    // R10 slave transfer
    cfg_master = 1'b0; loop_en = 1'b0;
    bus_wr(1, 8'hA5);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    got = '0;
    for (int b = 7; b >= 0; b--) begin
      sdi_drv = (8'h3C >> b) & 8'h01;
      sck_i = 1'b0;
      repeat (4) @(negedge clk);
      got[b] = sdo;
      sck_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    sck_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 slave done", irq_req, 1);
    chk("R10 slave sent", got, 8'hA5);
    bus_rd(0, d); chk("R10 status", d, 8'h81);
    bus_rd(1, d); chk("R10 slave rx", d, 8'h3C);
    ss_n_i = 1'b1;

    finish_run();
  end
endmodule